// File: doc/BRIEF.md
# Masked Multi-Address Slave Matcher

This block decides whether an address byte received on a two-wire serial bus is meant for this device. The received 7-bit address is compared against four programmable own-address entries at once. Each entry carries its own per-bit don't-care mask and a general-call enable. The result appears on registered outputs one cycle after the address strobe: an own-address match flag, the index of the entry that matched, and a separate general-call flag.

The surrounding slave controller shifts in the address byte and pulses the strobe when the byte is complete. It then reads the outputs to decide whether to acknowledge. The outputs keep their value until the next strobe, or until the bus reports a STOP or a repeated START. While the controller runs as a bus master, the entries are ignored. Shifting, acknowledge generation and status reporting are done elsewhere.

Top module: `slave_addr_match`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `addr_match`, `match_index` and `gen_call` are all 0.
- R2: The received address is `rx_byte[7:1]`; `rx_byte[0]` has no effect. The own address of entry i is bits [7:1] of `own_addr_regs[i]`. When `rx_valid` is high on a clock edge, the result is visible after that edge. Entry i matches when every unmasked address bit equals the stored bit.
- R3: Bit j of `mask_regs[i]` set to 1 makes received address bit j (that is, `rx_byte[j+1]`) a don't-care for entry i. Set to 0, that bit must match exactly.
- R4: When several entries match a nonzero address, `match_index` reports the lowest-numbered matching entry, with `addr_match` = 1 and `gen_call` = 0.
- R5: For received address 0, when at least one entry has its general-call bit (`own_addr_regs[i][0]`) set: `gen_call` = 1, `addr_match` = 0, and `match_index` = the lowest entry whose general-call bit is set.
- R6: For received address 0 with no general-call bit set, all outputs are 0. This holds even when an entry's address and mask would cover 0.
- R7: For a nonzero received address, `gen_call` is 0 whatever the general-call bits are.
- R8: A strobe taken while `master_mode` is 1 produces all-zero outputs, whatever the entries hold.
- R9: `bus_stop` or `bus_restart` high on a clock edge clears all outputs after that edge. This takes priority over a strobe in the same cycle.
- R10: With no strobe and no clear, the outputs hold their value, even while `rx_byte` or the registers change.
- R11: When no entry matches a nonzero address, `addr_match` = 0 and `match_index` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received address byte; address in [7:1], direction bit in [0] |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` complete |
| master_mode | input | 1 | Controller is currently a bus master |
| bus_stop | input | 1 | STOP condition seen |
| bus_restart | input | 1 | Repeated START seen |
| own_addr_regs | input | 4x8 | Per entry: address in [7:1], general-call enable in [0] |
| mask_regs | input | 4x7 | Per entry don't-care mask, bit j covers address bit j |
| addr_match | output | 1 | Received address matched an own-address entry |
| match_index | output | 2 | Index of the reporting entry |
| gen_call | output | 1 | General-call address accepted |

## Verification
The address strobe and a bus clear (STOP or repeated START) can arrive in the same cycle. The bench provokes this by raising `bus_restart` together with `rx_valid`, carrying an address that would otherwise match. It judges the case by requiring all-zero outputs after the edge, while the same address without the clear must produce a match. A second collision, an address that several entries accept, is judged by the reported index being the lowest candidate.

// File: rtl/sam_pkg.sv
package sam_pkg;

    parameter int ADDR_W  = 7;
    parameter int NUM_ENT = 4;
    parameter int REG_W   = ADDR_W + 1;
    parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef struct packed {
        logic             own_hit;
        logic [IDX_W-1:0] idx;
        logic             gc_hit;
    } sam_result_t;

    localparam sam_result_t SAM_NONE = '{own_hit: 1'b0, idx: '0, gc_hit: 1'b0};

    // an address is accepted when every cared-for bit agrees
    function automatic logic masked_equal(input logic [ADDR_W-1:0] rx,
                                          input logic [ADDR_W-1:0] own,
                                          input logic [ADDR_W-1:0] dc);
        return ((rx ^ own) & ~dc) == '0;
    endfunction

endpackage

// File: rtl/sam_entry_cmp.sv
module sam_entry_cmp #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW:0]   entry_reg,
    input  logic [AW-1:0] entry_mask,
    output logic          hit,
    output logic          gc_enabled
);
    import sam_pkg::*;

    always_comb begin
        hit        = masked_equal(rx_addr, entry_reg[AW:1], entry_mask);
        gc_enabled = entry_reg[0];
    end

endmodule

// File: rtl/sam_prio_enc.sv
module sam_prio_enc #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/sam_result_reg.sv
module sam_result_reg (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  clear,
    input  sam_pkg::sam_result_t  d,
    output sam_pkg::sam_result_t  q
);
    import sam_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clear) q <= SAM_NONE;
        else if (load)    q <= d;
    end

endmodule

// File: rtl/slave_addr_match.sv
module slave_addr_match
    import sam_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [7:0]                        rx_byte,
    input  logic                              rx_valid,
    input  logic                              master_mode,
    input  logic                              bus_stop,
    input  logic                              bus_restart,
    input  logic [NUM_ENT-1:0][REG_W-1:0]     own_addr_regs,
    input  logic [NUM_ENT-1:0][ADDR_W-1:0]    mask_regs,
    output logic                              addr_match,
    output logic [IDX_W-1:0]                  match_index,
    output logic                              gen_call
);

    logic [ADDR_W-1:0]  rx_addr;
    logic               unused_rw;
    logic               rx_is_zero;
    logic [NUM_ENT-1:0] ent_hit;
    logic [NUM_ENT-1:0] ent_gc;
    logic [NUM_ENT-1:0] own_req;
    logic [NUM_ENT-1:0] gc_req;
    logic               own_any;
    logic               gc_any;
    logic [IDX_W-1:0]   own_idx;
    logic [IDX_W-1:0]   gc_idx;
    sam_result_t        next_res;
    sam_result_t        cur_res;

    assign rx_addr    = rx_byte[7:1];
    assign unused_rw  = rx_byte[0];
    assign rx_is_zero = (rx_addr == '0);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_entry
        sam_entry_cmp #(.AW(ADDR_W)) u_cmp (
            .rx_addr    (rx_addr),
            .entry_reg  (own_addr_regs[g]),
            .entry_mask (mask_regs[g]),
            .hit        (ent_hit[g]),
            .gc_enabled (ent_gc[g])
        );
    end

    // the all-zero address is reserved for general call only
    assign own_req = rx_is_zero ? '0 : ent_hit;
    assign gc_req  = rx_is_zero ? ent_gc : '0;

    sam_prio_enc #(.N(NUM_ENT), .IW(IDX_W)) u_own_prio (
        .req (own_req),
        .any (own_any),
        .idx (own_idx)
    );

    sam_prio_enc #(.N(NUM_ENT), .IW(IDX_W)) u_gc_prio (
        .req (gc_req),
        .any (gc_any),
        .idx (gc_idx)
    );

    always_comb begin
        next_res = SAM_NONE;
        if (!master_mode) begin
            if (rx_is_zero) begin
                next_res.gc_hit = gc_any;
                next_res.idx    = gc_any ? gc_idx : '0;
            end else begin
                next_res.own_hit = own_any;
                next_res.idx     = own_any ? own_idx : '0;
            end
        end
    end

    sam_result_reg u_res (
        .clk   (clk),
        .rst   (rst),
        .load  (rx_valid),
        .clear (bus_stop | bus_restart),
        .d     (next_res),
        .q     (cur_res)
    );

    assign addr_match  = cur_res.own_hit;
    assign match_index = cur_res.idx;
    assign gen_call    = cur_res.gc_hit;

endmodule

// File: rtl/sam_checker.sv
module sam_checker
    import sam_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [7:0]       rx_byte,
    input logic             rx_valid,
    input logic             master_mode,
    input logic             bus_stop,
    input logic             bus_restart,
    input logic             addr_match,
    input logic [IDX_W-1:0] match_index,
    input logic             gen_call
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!addr_match && !gen_call && match_index == '0));

    // R9
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_stop || bus_restart) |=> (!addr_match && !gen_call && match_index == '0));

    // R4, R5
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(addr_match && gen_call));

    // R7
    a_r7_gc_needs_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !bus_stop && !bus_restart && rx_byte[7:1] != '0) |=> !gen_call);

    // R8
    a_r8_master_ignores: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && master_mode) |=> (!addr_match && !gen_call && match_index == '0));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !bus_stop && !bus_restart)
            |=> ($stable(addr_match) && $stable(gen_call) && $stable(match_index)));

    // R11
    a_r11_idx_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (!addr_match && !gen_call) |-> (match_index == '0));

endmodule

bind slave_addr_match sam_checker u_chk (.*);

// File: tb/slave_addr_match_test.sv
module slave_addr_match_test;
    import sam_pkg::*;

    logic                           clk = 1'b0;
    logic                           rst;
    logic [7:0]                     rx_byte;
    logic                           rx_valid;
    logic                           master_mode;
    logic                           bus_stop;
    logic                           bus_restart;
    logic [NUM_ENT-1:0][REG_W-1:0]  own_addr_regs;
    logic [NUM_ENT-1:0][ADDR_W-1:0] mask_regs;
    logic                           addr_match;
    logic [IDX_W-1:0]               match_index;
    logic                           gen_call;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    slave_addr_match uut (
        .clk           (clk),
        .rst           (rst),
        .rx_byte       (rx_byte),
        .rx_valid      (rx_valid),
        .master_mode   (master_mode),
        .bus_stop      (bus_stop),
        .bus_restart   (bus_restart),
        .own_addr_regs (own_addr_regs),
        .mask_regs     (mask_regs),
        .addr_match    (addr_match),
        .match_index   (match_index),
        .gen_call      (gen_call)
    );

    // {rx_byte, match, idx[1:0], gc} with the standard entry setup
    localparam logic [11:0] VEC [10] = '{
        {8'hA0, 1'b1, 2'd0, 1'b0},  // R4: entries 0 and 1 both accept 0x50
        {8'hB5, 1'b1, 2'd1, 1'b0},  // R3: 0x5A via entry 1 mask
        {8'h24, 1'b1, 2'd2, 1'b0},  // R2: exact 0x12
        {8'h25, 1'b1, 2'd2, 1'b0},  // R2: direction bit ignored
        {8'hE7, 1'b1, 2'd3, 1'b0},  // R3: 0x73 via entry 3 mask
        {8'hE8, 1'b0, 2'd0, 1'b0},  // R11: 0x74 matches none
        {8'h00, 1'b0, 2'd1, 1'b1},  // R5: general call, lowest gc entry 1
        {8'h01, 1'b0, 2'd1, 1'b1},  // R5: general call with read bit
        {8'h26, 1'b0, 2'd0, 1'b0},  // R11 / R7: 0x13 no match, no gc
        {8'hBF, 1'b1, 2'd1, 1'b0}   // R7: 0x5F entry 1, gc stays low
    };

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {addr_match, match_index, gen_call};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic std_setup();
        own_addr_regs[0] = {7'h50, 1'b0}; mask_regs[0] = 7'h00;
        own_addr_regs[1] = {7'h50, 1'b1}; mask_regs[1] = 7'h0F;
        own_addr_regs[2] = {7'h12, 1'b0}; mask_regs[2] = 7'h00;
        own_addr_regs[3] = {7'h70, 1'b1}; mask_regs[3] = 7'h03;
    endtask

    task automatic strobe(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_byte = 8'h00; rx_valid = 1'b0; master_mode = 1'b0;
        bus_stop = 1'b0; bus_restart = 1'b0;
        std_setup();
        repeat (3) @(negedge clk);
        check("R1 reset", 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 4'b0000);

        for (int i = 0; i < 10; i++) begin
            strobe(VEC[i][11:4]);
            check($sformatf("R2 vector %0d", i), VEC[i][3:0]);
        end

        // R10: hold while inputs wander
        strobe(8'h24);
        rx_byte = 8'hA0;
        own_addr_regs[2] = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 hold", 4'b1100);
        std_setup();

        // R9: stop clears
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
        check("R9 stop clears", 4'b0000);

        // R9: restart in same cycle as strobe wins
        strobe(8'h24);
        check("R9 reference match", 4'b1100);
        @(negedge clk);
        rx_byte = 8'hE7; rx_valid = 1'b1; bus_restart = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; bus_restart = 1'b0;
        check("R9 restart beats strobe", 4'b0000);

        // R8: master mode ignores entries
        strobe(8'hA0);
        master_mode = 1'b1;
        strobe(8'hA0);
        check("R8 master own addr", 4'b0000);
        strobe(8'h00);
        check("R8 master general call", 4'b0000);
        master_mode = 1'b0;

        // R6: zero address without any gc bit, entry 0 covers zero
        own_addr_regs[0] = 8'h00; mask_regs[0] = 7'h00;
        own_addr_regs[1] = {7'h50, 1'b0};
        own_addr_regs[3] = {7'h70, 1'b0};
        strobe(8'h00);
        check("R6 no gc enabled", 4'b0000);

        // R5: only entry 3 enables general call
        own_addr_regs[3] = {7'h70, 1'b1};
        strobe(8'h00);
        check("R5 gc entry 3", 4'b0111);

        // R7: all gc bits set, nonzero address with no match
        own_addr_regs[0] = 8'h01; own_addr_regs[1] = 8'h01;
        own_addr_regs[2] = 8'h01; own_addr_regs[3] = 8'h01;
        mask_regs = '0;
        strobe(8'h02);
        check("R7 nonzero no gc", 4'b0000);

        // R3: fully masked entry 2 accepts anything nonzero
        mask_regs[2] = 7'h7F;
        strobe(8'hFE);
        check("R3 full mask", 4'b1100);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 mid-run reset", 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule